// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches a bank of input pins, grouped into ports of eight, and turns selected pin activity into one bank interrupt. Every pin has its own trigger type: rising edge, falling edge, either edge, active-high level or active-low level. Each detected event sets a per-pin status bit. Software reads and clears the status through a 32-bit register bus, and per-pin enables decide which status bits reach the interrupt output. Pin inputs are expected to be synchronized to the clock before they arrive.

Each port has four registers: status, enable, trigger type and clear. Enable and type can also be written through a masked alias. A masked write changes only the pins it selects, so software needs no read-modify-write sequence. The type register holds three bits per pin, one in each of its three low byte lanes.

Top module: `gpio_irq_detector`

## Requirements
- R1: Port p's registers sit at byte address base + 4*p. The bases are status 0x40, enable 0x50, type 0x60 and clear 0x70. The clear register reads as zero. The masked enable alias is at UPPER_OFS + 0x50 and the masked type alias is at UPPER_OFS + 0x60. Reads at UPPER_OFS + 0x40/0x50/0x60 return status, enable and type.
- R2: While reset is held, status, enable and type read as zero and the interrupt is low.
- R3: Within a port's type register, pin n uses three bits: bit n is polarity, bit n+8 selects edge mode and bit n+16 selects both edges. Value 0x000101<<n means rising edge, and a 0-to-1 change on the pin sets status bit n.
- R4: Type value 0x000100<<n means falling edge. Only a 1-to-0 change sets status bit n.
- R5: Type value 0x010100<<n means both edges. Either change sets status bit n.
- R6: Type value 0x000001<<n means high level and a type of all zero means low level. Status bit n is set on every cycle the level is active, so a clear made while the level is still active leaves the bit set.
- R7: In an edge mode the status bit stays set after the pin returns to its earlier level, until software clears it.
- R8: Writing the clear register clears each status bit whose write bit is 1. Bits written as 0 leave their status unchanged.
- R9: If an edge is detected in the same cycle that a clear hits the same bit, the bit stays set.
- R10: The bank interrupt is high exactly when some port has a status bit whose enable bit is also set. An enabled bit in one port raises the interrupt regardless of the other ports.
- R11: A masked enable write uses bits 15:8 to select pins and bits 7:0 as their new values. Pins that are not selected keep their enable.
- R12: A masked type write uses the same select/value format and changes only the polarity bits (bit n) of the selected pins. The edge and both-edge bits are left unchanged.
- R13: The previous-pin value used for edge detection updates every cycle, whether or not the pin is enabled and in every trigger type. Switching a pin that is already high from level to rising mode therefore records no edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Byte address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| pinIn | input | NPORTS*8 | Synchronized pin levels; port p pin n is bit 8*p+n |
| bankIrq | output | 1 | Bank interrupt |

## Verification
The bench builds the block with its defaults: four ports, a 12-bit address and the masked aliases at offset 0x80. With four ports, every port-select bit of the address is exercised, and the interrupt OR is checked across ports whose enables differ. The alias offset sits above the register bases, so plain and masked writes to the same port can be compared directly. The directed scenarios cover each trigger type on a different port. They also cover a clear that collides with an edge, a clear made while a level is held, and a change of trigger type while a pin is already high.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_W = 8;

  typedef enum logic [1:0] {RD_NONE, RD_STATUS, RD_ENABLE, RD_TYPE} rdSel_e;

  // strobes from the address decoder to the datapath
  typedef struct packed {
    logic   enWr;
    logic   enMsk;
    logic   typWr;
    logic   typMsk;
    logic   clrWr;
    rdSel_e rdSel;
    logic [3:0] port;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h80
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output strobe_t           stb
);
  localparam int PORT_W = $clog2(NPORTS);
  localparam logic [ADDR_W-1:0] IDX_MASK = ADDR_W'(((NPORTS - 1) << 2) | 3);
  localparam logic [ADDR_W-1:0] OFS_STA  = ADDR_W'('h40);
  localparam logic [ADDR_W-1:0] OFS_ENB  = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] OFS_TYP  = ADDR_W'('h60);
  localparam logic [ADDR_W-1:0] OFS_CLR  = ADDR_W'('h70);
  localparam logic [ADDR_W-1:0] OFS_MSTA = ADDR_W'(UPPER_OFS + 'h40);
  localparam logic [ADDR_W-1:0] OFS_MENB = ADDR_W'(UPPER_OFS + 'h50);
  localparam logic [ADDR_W-1:0] OFS_MTYP = ADDR_W'(UPPER_OFS + 'h60);

  logic [ADDR_W-1:0] regBase;

  always_comb begin
    regBase   = regAddr & ~IDX_MASK;
    stb       = '0;
    stb.port  = 4'(regAddr[2 +: PORT_W]);
    stb.enWr  = regWrEn && (regBase == OFS_ENB);
    stb.enMsk = regWrEn && (regBase == OFS_MENB);
    stb.typWr = regWrEn && (regBase == OFS_TYP);
    stb.typMsk = regWrEn && (regBase == OFS_MTYP);
    stb.clrWr = regWrEn && (regBase == OFS_CLR);
    if (regBase == OFS_STA || regBase == OFS_MSTA)      stb.rdSel = RD_STATUS;
    else if (regBase == OFS_ENB || regBase == OFS_MENB) stb.rdSel = RD_ENABLE;
    else if (regBase == OFS_TYP || regBase == OFS_MTYP) stb.rdSel = RD_TYPE;
    else                                                stb.rdSel = RD_NONE;
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  logic [31:0]              wrData,
  input  logic [NPORTS*PIN_W-1:0]  pinIn,
  output logic [31:0]              rdData,
  output logic                     irq
);
  localparam int TOT = NPORTS * PIN_W;

  logic [TOT-1:0]     statusFlat;
  logic [TOT-1:0]     enableFlat;
  logic [3*TOT-1:0]   typeFlat;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [PIN_W-1:0]   statusR, enableR, prevR, hit, pinNow;
    logic [3*PIN_W-1:0] typeR;
    logic               sel;

    assign sel    = (stb.port == 4'(p));
    assign pinNow = pinIn[p*PIN_W +: PIN_W];

    always_comb begin
      for (int n = 0; n < PIN_W; n++) begin
        logic rise, fall;
        rise = pinNow[n] & ~prevR[n];
        fall = ~pinNow[n] & prevR[n];
        if (typeR[PIN_W + n]) begin
          if (typeR[2*PIN_W + n]) hit[n] = rise | fall;
          else                    hit[n] = typeR[n] ? rise : fall;
        end else begin
          hit[n] = (pinNow[n] == typeR[n]);
        end
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statusR <= '0;
        enableR <= '0;
        typeR   <= '0;
        prevR   <= '0;
      end else begin
        prevR <= pinNow;
        if (sel && stb.clrWr) statusR <= (statusR & ~wrData[PIN_W-1:0]) | hit;
        else                  statusR <= statusR | hit;
        if (sel && stb.enWr)
          enableR <= wrData[PIN_W-1:0];
        else if (sel && stb.enMsk)
          enableR <= (enableR & ~wrData[2*PIN_W-1:PIN_W]) |
                     (wrData[PIN_W-1:0] & wrData[2*PIN_W-1:PIN_W]);
        if (sel && stb.typWr)
          typeR <= wrData[3*PIN_W-1:0];
        else if (sel && stb.typMsk)
          typeR[PIN_W-1:0] <= (typeR[PIN_W-1:0] & ~wrData[2*PIN_W-1:PIN_W]) |
                              (wrData[PIN_W-1:0] & wrData[2*PIN_W-1:PIN_W]);
      end
    end

    assign statusFlat[p*PIN_W +: PIN_W]     = statusR;
    assign enableFlat[p*PIN_W +: PIN_W]     = enableR;
    assign typeFlat[p*3*PIN_W +: 3*PIN_W]   = typeR;
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NPORTS; p++) begin
      if (stb.port == 4'(p)) begin
        case (stb.rdSel)
          RD_STATUS: rdData = 32'(statusFlat[p*PIN_W +: PIN_W]);
          RD_ENABLE: rdData = 32'(enableFlat[p*PIN_W +: PIN_W]);
          RD_TYPE:   rdData = 32'(typeFlat[p*3*PIN_W +: 3*PIN_W]);
          default:   rdData = '0;
        endcase
      end
    end
  end

  assign irq = |(statusFlat & enableFlat);
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector
  import gpio_irq_pkg::*;
#(
  parameter int NPORTS    = 4,
  parameter int ADDR_W    = 12,
  parameter int UPPER_OFS = 'h80
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [31:0]             regWrData,
  output logic [31:0]             regRdData,
  input  logic [NPORTS*PIN_W-1:0] pinIn,
  output logic                    bankIrq
);
  strobe_t stb;

  gpio_irq_ctrl #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .UPPER_OFS(UPPER_OFS)) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .stb(stb)
  );

  gpio_irq_datapath #(.NPORTS(NPORTS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData),
    .pinIn(pinIn), .rdData(regRdData), .irq(bankIrq)
  );
endmodule

// File: rtl/gpio_irq_detector_chk.sv
module gpio_irq_detector_chk #(
  parameter int NPORTS = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  regWrEn,
  input logic                  bankIrq,
  input logic [NPORTS*8-1:0]   statusFlat,
  input logic [NPORTS*8-1:0]   enableFlat,
  input logic [NPORTS*24-1:0]  typeFlat
);
  // R7
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> (($past(statusFlat) & ~statusFlat) == '0));

  // R11
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(enableFlat));

  // R12
  type_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(typeFlat));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enableFlat == '0) |-> !bankIrq);
endmodule

bind gpio_irq_detector gpio_irq_detector_chk #(.NPORTS(NPORTS)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .bankIrq(bankIrq),
  .statusFlat(u_dp.statusFlat), .enableFlat(u_dp.enableFlat),
  .typeFlat(u_dp.typeFlat)
);

// File: tb/gpio_irq_detector_tb.sv
module gpio_irq_detector_tb;
  localparam int NPORTS = 4;
  localparam int ADDR_W = 12;
  localparam int UPPER  = 'h80;

  logic clk = 0, rstN = 0, regWrEn = 0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [NPORTS*8-1:0] pinIn = '0;
  logic bankIrq;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio_irq_detector #(.NPORTS(NPORTS), .ADDR_W(ADDR_W), .UPPER_OFS(UPPER)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn), .bankIrq(bankIrq)
  );

  function automatic logic [ADDR_W-1:0] ad(int base, int p);
    return ADDR_W'(base + 4 * p);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(int base, int p, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = ad(base, p); regWrData = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdChk(string req, int base, int p, logic [31:0] exp);
    regAddr = ad(base, p);
    #1;
    chk(req, regRdData, exp);
  endtask

  task automatic setPin(int p, int n, logic v);
    @(negedge clk);
    pinIn[p*8+n] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rdChk("R2 status", 'h40, 0, 0);
    rdChk("R2 enable", 'h50, 1, 0);
    rdChk("R2 type", 'h60, 2, 0);
    chk("R2 irq", 32'(bankIrq), 0);
  endtask

  task automatic t_init();
    for (int p = 0; p < NPORTS; p++) wr('h60, p, 32'h00FFFF);
    for (int p = 0; p < NPORTS; p++) wr('h70, p, 32'hFF);
    for (int p = 0; p < NPORTS; p++) rdChk("R1 status cleared", 'h40, p, 0);
    rdChk("R1 type readback", 'h60, 3, 32'h00FFFF);
    rdChk("R1 clear reads zero", 'h70, 0, 0);
  endtask

  task automatic t_rising();
    setPin(1, 3, 1);
    rdChk("R3 rising sets", 'h40, 1, 32'h08);
    setPin(1, 3, 0);
    rdChk("R7 sticky", 'h40, 1, 32'h08);
    chk("R10 irq off when disabled", 32'(bankIrq), 0);
    wr('h50, 1, 32'h08);
    chk("R10 irq on", 32'(bankIrq), 1);
    setPin(1, 5, 1);
    wr('h70, 1, 32'h08);
    rdChk("R8 zero bits kept", 'h40, 1, 32'h20);
    chk("R10 irq off after clear", 32'(bankIrq), 0);
    wr('h70, 1, 32'h20);
    setPin(1, 5, 0);
    rdChk("R3 no set on fall", 'h40, 1, 0);
    wr('h50, 1, 0);
  endtask

  task automatic t_falling();
    wr('h60, 2, 32'h00FF00);
    setPin(2, 0, 1);
    rdChk("R4 no set on rise", 'h40, 2, 0);
    setPin(2, 0, 0);
    rdChk("R4 falling sets", 'h40, 2, 32'h01);
    wr('h70, 2, 32'hFF);
  endtask

  task automatic t_both();
    wr('h60, 3, 32'hFFFF00);
    setPin(3, 6, 1);
    rdChk("R5 rise sets", 'h40, 3, 32'h40);
    wr('h70, 3, 32'h40);
    rdChk("R5 cleared", 'h40, 3, 0);
    setPin(3, 6, 0);
    rdChk("R5 fall sets", 'h40, 3, 32'h40);
    wr('h50, 3, 32'h40);
    chk("R10 irq from port3", 32'(bankIrq), 1);
    wr('h70, 3, 32'hFF);
    wr('h50, 3, 0);
  endtask

  task automatic t_level();
    setPin(0, 2, 1);
    wr('h60, 0, 32'h0000FF);
    wr('h70, 0, 32'hFF);
    rdChk("R6 level high clear overridden", 'h40, 0, 32'h04);
    setPin(0, 2, 0);
    wr('h70, 0, 32'hFF);
    rdChk("R6 level high gone", 'h40, 0, 0);
    wr('h60, 0, 32'h000000);
    setPin(0, 2, 1);
    wr('h70, 0, 32'hFF);
    rdChk("R6 level low", 'h40, 0, 32'hFB);
    setPin(0, 2, 0);
    wr('h60, 0, 32'h00FFFF);
    wr('h70, 0, 32'hFF);
  endtask

  task automatic t_collide();
    @(negedge clk);
    pinIn[1*8+4] = 1;
    regWrEn = 1; regAddr = ad('h70, 1); regWrData = 32'h10;
    @(negedge clk);
    regWrEn = 0;
    rdChk("R9 set wins", 'h40, 1, 32'h10);
    setPin(1, 4, 0);
    wr('h70, 1, 32'hFF);
  endtask

  task automatic t_masked();
    wr('h50, 2, 32'hF0);
    wr(UPPER + 'h50, 2, 32'h0381);
    rdChk("R11 masked enable", 'h50, 2, 32'hF1);
    rdChk("R1 alias read", UPPER + 'h50, 2, 32'hF1);
    wr(UPPER + 'h60, 0, 32'h0100);
    rdChk("R12 masked type", 'h60, 0, 32'h00FFFE);
    wr('h50, 2, 0);
    wr('h60, 0, 32'h00FFFF);
  endtask

  task automatic t_prev();
    wr('h60, 0, 32'h0000FF);
    setPin(0, 7, 1);
    wr('h60, 0, 32'h00FFFF);
    wr('h70, 0, 32'hFF);
    @(negedge clk);
    rdChk("R13 no spurious edge", 'h40, 0, 0);
    setPin(0, 7, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    t_init();
    t_rising();
    t_falling();
    t_both();
    t_level();
    t_collide();
    t_masked();
    t_prev();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule